// File: doc/BRIEF.md
# Boot-Block Swap Address Decoder

This block sorts processor memory requests into four destinations: the firmware device, a 1 KB event-timer window, a 1 KB USB host window and the PCI default. For cycles that go to the firmware device it can invert address bit 16. With that bit inverted, the top 64 KB block and the block just below it trade places. Software can then rewrite the boot block while a verified copy answers the reset vector.

A two-register configuration port holds the settings. Register 0 holds the swap enable and a swap lock-down bit. These bits sit in a battery-backed domain that only the real-time-clock reset clears. Register 1 holds the routing controls, which the platform reset also clears.

Requests enter on a valid/ready stream. Each result leaves on a second valid/ready stream through a single output register, one clock after acceptance.

Back-pressure rules:
- A request is taken on any clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high when the output register is empty or is being drained that same cycle.
- While `rsp_valid` is high and `rsp_ready` is low, the result holds steady and `req_ready` stays low.

Top module: `bootswap_decoder`

## Requirements
- R1: With swap enable 0, boot destination 1 and firmware decode enable 1, every address in FFF0_0000h–FFFF_FFFFh leaves unchanged with target code 1 (firmware).
- R2: With swap enable 1, each firmware-targeted address leaves with bit 16 inverted. For example FFFF_0000h becomes FFFE_0000h, FFFE_ABCDh becomes FFFF_ABCDh and FFF0_0000h becomes FFF1_0000h. Other targets are never remapped.
- R3: Platform reset (`plt_rst_n` low) returns register 1 to all zeros and leaves swap enable and lock as they were. The real-time-clock reset (`rtc_rst_n` low) clears both registers.
- R4: Register 0 bit 1 (lock) can only be set, never cleared, by writes. While it is 1, writes to register 0 bit 0 (swap enable) are ignored. Only the real-time-clock reset clears it.
- R5: With register 1 bit 2 (timer enable) set, addresses FED0_0000h + S·1000h through that base + 3FFh give target code 2. S is register 1 bits 5:4. Addresses one below the window, one above it, and in windows for other S values go to PCI.
- R6: With register 1 bit 0 (boot destination) at 0, firmware-space addresses go to PCI (code 0) unchanged, whatever the decode enable and swap bits hold.
- R7: With boot destination 1 but register 1 bit 1 (firmware decode enable) at 0, firmware-space addresses go to PCI unchanged.
- R8: `rsp_lock` copies `req_lock` except for timer (code 2) and USB (code 3) results, where it is 0.
- R9: Addresses that match no enabled window, including FFEF_FFFFh just below firmware space, go to PCI (code 0) unchanged.
- R10: A result appears on `rsp_valid` in the cycle after acceptance. It holds with a stable payload and `req_ready` low while `rsp_ready` is low.
- R11: With register 1 bit 3 (USB enable) set, addresses FEB4_0000h–FEB4_03FFh give target code 3. FEB4_0400h and all addresses in that window with the enable clear go to PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | Battery-domain reset, asynchronous, active low |
| plt_rst_n | input | 1 | Platform reset, asynchronous, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 swap/lock, 1 routing |
| cfg_wdata | input | 6 | Write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Request address |
| req_lock | input | 1 | Request is a locked cycle |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_target | output | 2 | 0 PCI, 1 firmware, 2 timer, 3 USB |
| rsp_addr | output | 32 | Address after any swap |
| rsp_lock | output | 1 | Lock that is honoured |

## Verification
Addresses at the first and last byte of every window, and one byte outside each edge, are decoded with the swap bit both clear and set. This separates an off-by-one window compare from a wrong remap. The firmware block is tried at its top, the next block down and its bottom. That shows the inversion is a single-bit flip over the whole space and not a swap of just two blocks. Each of the four timer selects is matched against its own base and a neighbour's base, which catches a wrong stride or a select that is ignored. Reset and lock sequences write the swap bit after each reset kind, so the two reset domains can be told apart.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int TSEL_W = 2;

  typedef enum logic [1:0] {
    TGT_PCI = 2'd0,
    TGT_FWH = 2'd1,
    TGT_TMR = 2'd2,
    TGT_USB = 2'd3
  } bsd_tgt_e;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic              usb_en;
    logic              tmr_en;
    logic              fw_dec_en;
    logic              fw_dest;
  } bsd_route_t;
endpackage

// File: rtl/bsd_cfg_regs.sv
module bsd_cfg_regs
  import bsd_pkg::*;
#(
  parameter int CFG_W = 6
) (
  input  logic             clk,
  input  logic             rtc_rst_n,
  input  logic             plt_rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             swap_en,
  output logic             swap_lock,
  output bsd_route_t       route
);
  localparam int ROUTE_W = $bits(bsd_route_t);

  logic wr_swap, wr_route;
  assign wr_swap  = cfg_we && (cfg_addr == 1'b0);
  assign wr_route = cfg_we && (cfg_addr == 1'b1);

  // battery domain: only the RTC reset clears it
  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      swap_en   <= 1'b0;
      swap_lock <= 1'b0;
    end else if (wr_swap) begin
      if (!swap_lock) swap_en <= cfg_wdata[0];
      swap_lock <= swap_lock | cfg_wdata[1];
    end
  end

  // platform domain
  always_ff @(posedge clk or negedge rtc_rst_n or negedge plt_rst_n) begin
    if (!rtc_rst_n || !plt_rst_n) begin
      route <= '0;
    end else if (wr_route) begin
      route <= bsd_route_t'(cfg_wdata[ROUTE_W-1:0]);
    end
  end
endmodule

// File: rtl/bsd_win_match.sv
module bsd_win_match #(
  parameter int ADDR_W    = 32,
  parameter int SPAN_LOG2 = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              en,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << SPAN_LOG2;
  assign hit = en && (((addr ^ base) & MASK) == '0);
endmodule

// File: rtl/bsd_decode.sv
module bsd_decode
  import bsd_pkg::*;
#(
  parameter int              ADDR_W        = 32,
  parameter int              SWAP_BIT      = 16,
  parameter int              FW_SPAN_LOG2  = 20,
  parameter logic [ADDR_W-1:0] TMR_BASE    = 32'hFED0_0000,
  parameter int              TMR_SPAN_LOG2 = 10,
  parameter int              TMR_STEP_LOG2 = 12,
  parameter logic [ADDR_W-1:0] USB_BASE    = 32'hFEB4_0000,
  parameter int              USB_SPAN_LOG2 = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  input  logic              swap_en,
  input  bsd_route_t        route,
  output bsd_tgt_e          target,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_lock
);
  localparam logic [ADDR_W-1:0] FW_BASE   = {ADDR_W{1'b1}} << FW_SPAN_LOG2;
  localparam logic [ADDR_W-1:0] SWAP_MASK = {{(ADDR_W-1){1'b0}}, 1'b1} << SWAP_BIT;

  logic [ADDR_W-1:0] tmr_base;
  logic hit_tmr, hit_usb, hit_fw;

  assign tmr_base = TMR_BASE +
    ({{(ADDR_W-TSEL_W){1'b0}}, route.tsel} << TMR_STEP_LOG2);

  bsd_win_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(TMR_SPAN_LOG2)) u_tmr (
    .addr(addr), .base(tmr_base), .en(route.tmr_en), .hit(hit_tmr));

  bsd_win_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(USB_SPAN_LOG2)) u_usb (
    .addr(addr), .base(USB_BASE), .en(route.usb_en), .hit(hit_usb));

  bsd_win_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(FW_SPAN_LOG2)) u_fw (
    .addr(addr), .base(FW_BASE), .en(route.fw_dest && route.fw_dec_en),
    .hit(hit_fw));

  always_comb begin
    target   = TGT_PCI;
    out_addr = addr;
    if (hit_tmr)      target = TGT_TMR;
    else if (hit_usb) target = TGT_USB;
    else if (hit_fw) begin
      target = TGT_FWH;
      if (swap_en) out_addr = addr ^ SWAP_MASK;
    end
  end

  assign out_lock = lock && !(hit_tmr || hit_usb);
endmodule

// File: rtl/bsd_out_stage.sv
module bsd_out_stage #(
  parameter int PAY_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pay <= in_pay;
    end
  end
endmodule

// File: rtl/bootswap_decoder.sv
module bootswap_decoder
  import bsd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CFG_W    = 6,
  parameter int SWAP_BIT = 16
) (
  input  logic              clk,
  input  logic              rtc_rst_n,
  input  logic              plt_rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_lock,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_target,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_lock
);
  localparam int PAY_W = ADDR_W + 3;

  logic              sys_rst_n;
  logic              swap_en, swap_lock;
  bsd_route_t        route;
  bsd_tgt_e          dec_tgt;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_lock;
  logic [PAY_W-1:0]  pay_q;

  assign sys_rst_n = rtc_rst_n && plt_rst_n;

  bsd_cfg_regs #(.CFG_W(CFG_W)) u_regs (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .plt_rst_n(plt_rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .swap_en(swap_en), .swap_lock(swap_lock), .route(route));

  bsd_decode #(.ADDR_W(ADDR_W), .SWAP_BIT(SWAP_BIT)) u_dec (
    .addr(req_addr), .lock(req_lock), .swap_en(swap_en), .route(route),
    .target(dec_tgt), .out_addr(dec_addr), .out_lock(dec_lock));

  bsd_out_stage #(.PAY_W(PAY_W)) u_out (
    .clk(clk), .rst_n(sys_rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_pay({dec_lock, dec_tgt, dec_addr}),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_pay(pay_q));

  assign rsp_addr   = pay_q[ADDR_W-1:0];
  assign rsp_target = pay_q[ADDR_W+1:ADDR_W];
  assign rsp_lock   = pay_q[ADDR_W+2];
endmodule

// File: rtl/bsd_chk.sv
module bsd_chk #(
  parameter int ADDR_W   = 32,
  parameter int SWAP_BIT = 16
) (
  input logic              clk,
  input logic              rtc_rst_n,
  input logic              plt_rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_target,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_lock,
  input logic              swap_lock
);
  localparam logic [ADDR_W-1:0] KEEP = ~({{(ADDR_W-1){1'b0}}, 1'b1} << SWAP_BIT);

  logic fire;
  assign fire = req_valid && req_ready;

  // R10
  accept_then_valid_chk: assert property (@(posedge clk)
    disable iff (!rtc_rst_n || !plt_rst_n) fire |=> rsp_valid);

  // R10
  hold_when_stalled_chk: assert property (@(posedge clk)
    disable iff (!rtc_rst_n || !plt_rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_target) && $stable(rsp_lock)));

  // R8
  lock_dropped_chk: assert property (@(posedge clk)
    disable iff (!rtc_rst_n || !plt_rst_n)
    (rsp_valid && rsp_target[1]) |-> !rsp_lock);

  // R2
  only_bit16_flips_chk: assert property (@(posedge clk)
    disable iff (!rtc_rst_n || !plt_rst_n)
    fire |=> (((rsp_addr ^ $past(req_addr)) & KEEP) == '0));

  // R9
  non_fw_unchanged_chk: assert property (@(posedge clk)
    disable iff (!rtc_rst_n || !plt_rst_n)
    fire |=> (rsp_target == 2'd1 || rsp_addr == $past(req_addr)));

  // R4
  lock_sticky_chk: assert property (@(posedge clk)
    disable iff (!rtc_rst_n) swap_lock |=> swap_lock);
endmodule

bind bootswap_decoder bsd_chk #(.ADDR_W(ADDR_W), .SWAP_BIT(SWAP_BIT)) u_chk (
  .clk(clk), .rtc_rst_n(rtc_rst_n), .plt_rst_n(plt_rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_target(rsp_target),
  .rsp_addr(rsp_addr), .rsp_lock(rsp_lock), .swap_lock(swap_lock));

// File: tb/sim_bootswap_decoder.sv
module sim_bootswap_decoder;
  logic        clk = 1'b0;
  logic        rtc_rst_n = 1'b0, plt_rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [5:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0, req_lock = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_lock;
  logic [1:0]  rsp_target;
  logic [31:0] rsp_addr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bootswap_decoder u0 (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .plt_rst_n(plt_rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_lock(req_lock), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_target(rsp_target), .rsp_addr(rsp_addr), .rsp_lock(rsp_lock));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic a, input logic [5:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic req(input logic [31:0] a, input logic lk, input logic [1:0] et,
                     input logic [31:0] ea, input logic el, input string tag);
    @(negedge clk); req_valid = 1'b1; req_addr = a; req_lock = lk;
    @(negedge clk); req_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_target === et && rsp_addr === ea && rsp_lock === el,
          tag, {rsp_valid, rsp_lock, rsp_target, rsp_addr}, {1'b1, el, et, ea});
  endtask

  task automatic t_reset;
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R10 reset", {rsp_valid, req_ready}, 2'b01);
    req(32'hFFFF_0000, 0, 2'd0, 32'hFFFF_0000, 0, "R6 reset routing to PCI");
  endtask

  task automatic t_fw_plain;
    cfg(1, 6'h03);
    req(32'hFFF0_0000, 0, 2'd1, 32'hFFF0_0000, 0, "R1 fw bottom");
    req(32'hFFFE_1234, 0, 2'd1, 32'hFFFE_1234, 0, "R1 fw next block");
    req(32'hFFFF_FFFF, 0, 2'd1, 32'hFFFF_FFFF, 0, "R1 fw top");
    req(32'hFFEF_FFFF, 0, 2'd0, 32'hFFEF_FFFF, 0, "R9 below fw");
    req(32'h0000_1000, 0, 2'd0, 32'h0000_1000, 0, "R9 low memory");
  endtask

  task automatic t_swap;
    cfg(0, 6'h01);
    req(32'hFFFF_0000, 0, 2'd1, 32'hFFFE_0000, 0, "R2 top to next");
    req(32'hFFFF_FFFF, 0, 2'd1, 32'hFFFE_FFFF, 0, "R2 top end");
    req(32'hFFFE_ABCD, 0, 2'd1, 32'hFFFF_ABCD, 0, "R2 next to top");
    req(32'hFFF0_0000, 0, 2'd1, 32'hFFF1_0000, 0, "R2 fw bottom flips");
    req(32'h0001_0000, 0, 2'd0, 32'h0001_0000, 0, "R2 non-fw not remapped");
  endtask

  task automatic t_dest;
    cfg(1, 6'h02);
    req(32'hFFFF_0000, 0, 2'd0, 32'hFFFF_0000, 0, "R6 dest 0 with swap");
    cfg(1, 6'h00);
    req(32'hFFFE_0000, 0, 2'd0, 32'hFFFE_0000, 0, "R6 dest 0 enable 0");
    cfg(1, 6'h01);
    req(32'hFFFF_0000, 0, 2'd0, 32'hFFFF_0000, 0, "R7 decode disabled");
  endtask

  task automatic t_timer;
    for (int s = 0; s < 4; s++) begin
      logic [31:0] b, ob;
      b  = 32'hFED0_0000 + 32'(s) * 32'h1000;
      ob = 32'hFED0_0000 + 32'((s + 1) % 4) * 32'h1000;
      cfg(1, 6'h07 | 6'(s << 4));
      req(b,              0, 2'd2, b,              0, "R5 window base");
      req(b + 32'h3FF,    0, 2'd2, b + 32'h3FF,    0, "R5 window last");
      req(b + 32'h400,    0, 2'd0, b + 32'h400,    0, "R5 above window");
      req(b - 32'h1,      0, 2'd0, b - 32'h1,      0, "R5 below window");
      req(ob,             0, 2'd0, ob,             0, "R5 other select");
    end
    cfg(1, 6'h03);
    req(32'hFED0_0000, 0, 2'd0, 32'hFED0_0000, 0, "R5 timer disabled");
  endtask

  task automatic t_usb;
    cfg(1, 6'h0B);
    req(32'hFEB4_0000, 0, 2'd3, 32'hFEB4_0000, 0, "R11 base");
    req(32'hFEB4_03FF, 0, 2'd3, 32'hFEB4_03FF, 0, "R11 last");
    req(32'hFEB4_0400, 0, 2'd0, 32'hFEB4_0400, 0, "R11 above");
    cfg(1, 6'h03);
    req(32'hFEB4_0000, 0, 2'd0, 32'hFEB4_0000, 0, "R11 disabled");
  endtask

  task automatic t_locks;
    cfg(1, 6'h0F);
    req(32'hFED0_0010, 1, 2'd2, 32'hFED0_0010, 0, "R8 timer lock dropped");
    req(32'hFEB4_0010, 1, 2'd3, 32'hFEB4_0010, 0, "R8 usb lock dropped");
    req(32'hFFFF_0010, 1, 2'd1, 32'hFFFE_0010, 1, "R8 fw lock kept");
    req(32'h0000_2000, 1, 2'd0, 32'h0000_2000, 1, "R8 pci lock kept");
  endtask

  task automatic t_lockdown;
    cfg(1, 6'h03);
    cfg(0, 6'h03);
    cfg(0, 6'h00);
    req(32'hFFFF_0000, 0, 2'd1, 32'hFFFE_0000, 0, "R4 clear ignored");
  endtask

  task automatic t_resets;
    @(negedge clk); plt_rst_n = 1'b0;
    @(negedge clk); plt_rst_n = 1'b1;
    req(32'hFFFF_0000, 0, 2'd0, 32'hFFFF_0000, 0, "R3 routing cleared by platform reset");
    cfg(1, 6'h03);
    req(32'hFFFF_0000, 0, 2'd1, 32'hFFFE_0000, 0, "R3 swap survives platform reset");
    cfg(0, 6'h00);
    req(32'hFFFF_0000, 0, 2'd1, 32'hFFFE_0000, 0, "R4 lock survives platform reset");
    @(negedge clk); rtc_rst_n = 1'b0;
    @(negedge clk); rtc_rst_n = 1'b1;
    cfg(1, 6'h03);
    req(32'hFFFF_0000, 0, 2'd1, 32'hFFFF_0000, 0, "R3 swap cleared by rtc reset");
    cfg(0, 6'h01);
    req(32'hFFFF_0000, 0, 2'd1, 32'hFFFE_0000, 0, "R4 lock cleared by rtc reset");
  endtask

  task automatic t_stall;
    @(negedge clk); rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h1234_5678; req_lock = 0;
    @(negedge clk); req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(rsp_valid === 1'b1 && req_ready === 1'b0 && rsp_addr === 32'h1234_5678,
            "R10 held while stalled", {rsp_valid, req_ready, rsp_addr}, {2'b10, 32'h1234_5678});
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R10 drained", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rtc_rst_n = 1'b1; plt_rst_n = 1'b1;
    t_reset;
    t_fw_plain;
    t_swap;
    t_dest;
    t_timer;
    t_usb;
    t_locks;
    t_lockdown;
    t_resets;
    t_stall;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule